// File: doc/BRIEF.md
# Diskette Controller Host Register File

This block is the programmed-I/O face of a diskette controller on an 8-bit host bus. The host reaches it through an eight-port window at a base address. A second eight-port window sits 16 ports higher, and both windows reach the same registers. Through these ports the host reads the controller status, reads and acknowledges the result type, and reads a result byte. It also builds the 16-bit address of a parameter block in memory from two byte writes.

The second address write also starts the operation. The operation engine is not part of this block. It receives a one-cycle start pulse with the assembled address. When the engine finishes, it reports back through a completion strobe that carries the result type, result byte 0 and a ready-change indication, and this completion sets the interrupt flip-flop. Writes to two further ports emit one-cycle stop and system-reset pulses to the engine.

Bus accesses are single-cycle and have no wait states. `bus_rdata` is combinational from the registers during a read cycle. The side effects of an access take place at the clock edge that ends the cycle. The completion strobe is a plain control input with no back-pressure: the register file always accepts it.

Top module: `dskc_hostregs`

## Requirements
- R1: Port addresses BASE..BASE+7 and BASE+ALIAS_GAP..BASE+ALIAS_GAP+7 decode to offsets 0..7 of the same register set. An access at any other address changes no state and reads 0x00.
- R2: A read at offset 0 returns the status byte. Bits [7:4] are the ready bits of drives 3..0, bit 2 is the status interrupt bit, bit 0 is always 1, and the other bits are 0.
- R3: A read at offset 1 returns the result type. The access clears both the interrupt flip-flop (`irq`) and the status interrupt bit.
- R4: A write at offset 1 sets the parameter address to {0x00, data}, replacing its old value.
- R5: A write at offset 2 ORs the data into address bits [15:8] and raises `start_pulse` for exactly the next cycle. If `irq` was set before the write, it also sets the status interrupt bit.
- R6: A completion strobe sets `irq`, loads the result type and result byte 0, and sets the ready-change flag when `done_rdychg` is 1. A flag that is already set stays set.
- R7: A read at offset 3 returns result byte 0 while the result type is 0x00.
- R8: A read at offset 3 with a nonzero result type returns the drive-ready byte if the ready-change flag is set, and 0x00 if it is not. In the drive-ready byte, bits 3..0 are 0, bit 4 is drive 2, bit 5 is drive 3, bit 6 is drive 0 and bit 7 is drive 1.
- R9: After reset the ready bits equal DRIVE_MASK, the result type is 0x00 (OK), result byte 0 is 0x00, the ready-change flag, `irq` and the status interrupt bit are clear, the parameter address is 0 and all pulses are low.
- R10: A write at offset 3 raises `stop_pulse` for one cycle. A write at offset 7 raises `sysrst_pulse` for one cycle and returns the result type, result byte 0, ready-change flag, `irq` and status interrupt bit to their reset values. The parameter address is kept.
- R11: A read at offset 2, 4, 5, 6 or 7 returns 0x00. A write at offset 0, 4, 5 or 6 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Host access cycle active |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Host port address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when no decoded read is in progress |
| done_valid | input | 1 | Operation completion strobe |
| done_rtype | input | 8 | Result type reported with the completion |
| done_rbyte0 | input | 8 | Result byte 0 (bit 5 write protect, bit 6 write error, bit 7 not ready) |
| done_rdychg | input | 1 | Drive ready state changed during the operation |
| pblk_addr | output | 16 | Assembled parameter block address |
| start_pulse | output | 1 | One-cycle operation start |
| stop_pulse | output | 1 | One-cycle stop request |
| sysrst_pulse | output | 1 | One-cycle diskette-system reset request |
| irq | output | 1 | Interrupt flip-flop |

## Verification
The bench builds the block with BASE 0x78, ALIAS_GAP 16 and DRIVE_MASK 4'b1011. With a non-uniform mask, a swapped or shifted bit in the drive-ready byte or in the status nibble shows up as a wrong value. Because the base is not aligned to 16, both windows start inside a 16-port block, so the addresses just below, between and just above the windows exercise the edges of both range comparisons. Random accesses spread over all sixteen decoded addresses and their neighbours, mixed with completions carrying zero and nonzero result types, reach every ordering of completion, acknowledge and high-address write.

// File: rtl/dskc_pkg.sv
package dskc_pkg;
  localparam int OFF_W = 3;

  typedef enum logic [OFF_W-1:0] {
    OFF_STAT = 3'd0,
    OFF_TYPE = 3'd1,
    OFF_HI   = 3'd2,
    OFF_RES  = 3'd3,
    OFF_SYS  = 3'd7
  } port_off_e;

  localparam logic [7:0] RTYPE_OK = 8'h00;

  // drive-ready byte: drive0->bit6, drive1->bit7, drive2->bit4, drive3->bit5
  function automatic logic [7:0] ready_byte(input logic [3:0] rdy);
    ready_byte = {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
  endfunction

  function automatic logic [7:0] status_byte(input logic [3:0] rdy, input logic int_bit);
    status_byte = {rdy, 1'b0, int_bit, 1'b0, 1'b1};
  endfunction
endpackage

// File: rtl/dskc_decode.sv
module dskc_decode #(
  parameter int ADDR_W    = 8,
  parameter int BASE      = 8'h78,
  parameter int ALIAS_GAP = 16
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [dskc_pkg::OFF_W-1:0] off
);
  localparam int WIN = 1 << dskc_pkg::OFF_W;
  localparam logic [ADDR_W:0] BASE_X  = BASE[ADDR_W:0];
  localparam logic [ADDR_W:0] ALIAS_X = BASE_X + ALIAS_GAP[ADDR_W:0];
  localparam logic [ADDR_W:0] WIN_X   = WIN[ADDR_W:0];

  logic [ADDR_W:0] d_main, d_alias;
  logic in_main, in_alias;

  always_comb begin
    d_main   = {1'b0, addr} - BASE_X;
    d_alias  = {1'b0, addr} - ALIAS_X;
    in_main  = d_main < WIN_X;
    in_alias = d_alias < WIN_X;
    hit      = in_main | in_alias;
    off      = in_main ? d_main[dskc_pkg::OFF_W-1:0] : d_alias[dskc_pkg::OFF_W-1:0];
  end
endmodule

// File: rtl/dskc_pblk.sv
module dskc_pblk #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [7:0]    data,
  output logic [AW-1:0] addr,
  output logic          start
);
  localparam int HI_W = AW - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      start <= 1'b0;
    end else begin
      start <= wr_hi;
      if (wr_lo)
        addr <= {{HI_W{1'b0}}, data};
      else if (wr_hi)
        addr[AW-1:8] <= addr[AW-1:8] | data[HI_W-1:0];
    end
  end
endmodule

// File: rtl/dskc_irq.sv
module dskc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic ack,
  input  logic arm,
  input  logic clr,
  output logic intff,
  output logic stat_int
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intff    <= 1'b0;
      stat_int <= 1'b0;
    end else if (clr) begin
      intff    <= 1'b0;
      stat_int <= 1'b0;
    end else begin
      if (done)     intff <= 1'b1;
      else if (ack) intff <= 1'b0;
      if (ack)                stat_int <= 1'b0;
      else if (arm && intff)  stat_int <= 1'b1;
    end
  end
endmodule

// File: rtl/dskc_hostregs.sv
module dskc_hostregs #(
  parameter int         ADDR_W     = 8,
  parameter int         BASE       = 8'h78,
  parameter int         ALIAS_GAP  = 16,
  parameter logic [3:0] DRIVE_MASK = 4'b0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              done_valid,
  input  logic [7:0]        done_rtype,
  input  logic [7:0]        done_rbyte0,
  input  logic              done_rdychg,
  output logic [15:0]       pblk_addr,
  output logic              start_pulse,
  output logic              stop_pulse,
  output logic              sysrst_pulse,
  output logic              irq
);
  import dskc_pkg::*;

  logic             hit;
  logic [OFF_W-1:0] off;
  logic             rd_en, wr_en;
  logic             wr_lo, wr_hi, wr_stop, wr_sys, rd_type;
  logic             stat_int;
  logic [3:0]       drv_rdy;
  logic [7:0]       rtype_q, rbyte0_q;
  logic             rdychg_q;

  dskc_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .ALIAS_GAP(ALIAS_GAP)) u_dec (
    .addr(bus_addr), .hit(hit), .off(off)
  );

  always_comb begin
    rd_en   = bus_cs & ~bus_wr & hit;
    wr_en   = bus_cs &  bus_wr & hit;
    wr_lo   = wr_en & (off == OFF_TYPE);
    wr_hi   = wr_en & (off == OFF_HI);
    wr_stop = wr_en & (off == OFF_RES);
    wr_sys  = wr_en & (off == OFF_SYS);
    rd_type = rd_en & (off == OFF_TYPE);
  end

  dskc_pblk #(.AW(16)) u_pblk (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .data(bus_wdata), .addr(pblk_addr), .start(start_pulse)
  );

  dskc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(done_valid), .ack(rd_type),
    .arm(wr_hi), .clr(wr_sys), .intff(irq), .stat_int(stat_int)
  );

  // drive ready bits, one flop per drive position
  for (genvar g = 0; g < 4; g++) begin : g_drv
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_rdy[g] <= DRIVE_MASK[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtype_q      <= RTYPE_OK;
      rbyte0_q     <= 8'h00;
      rdychg_q     <= 1'b0;
      stop_pulse   <= 1'b0;
      sysrst_pulse <= 1'b0;
    end else begin
      stop_pulse   <= wr_stop;
      sysrst_pulse <= wr_sys;
      if (wr_sys) begin
        rtype_q  <= RTYPE_OK;
        rbyte0_q <= 8'h00;
        rdychg_q <= 1'b0;
      end else if (done_valid) begin
        rtype_q  <= done_rtype;
        rbyte0_q <= done_rbyte0;
        if (done_rdychg) rdychg_q <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (rd_en) begin
      case (off)
        OFF_STAT: bus_rdata = status_byte(drv_rdy, stat_int);
        OFF_TYPE: bus_rdata = rtype_q;
        OFF_RES:  bus_rdata = (rtype_q == RTYPE_OK) ? rbyte0_q :
                              (rdychg_q ? ready_byte(drv_rdy) : 8'h00);
        default:  bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/dskc_hostregs_chk.sv
module dskc_hostregs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_cs,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       hit,
  input logic [2:0] off,
  input logic       done_valid,
  input logic [15:0] pblk_addr,
  input logic       start_pulse,
  input logic       stop_pulse,
  input logic       irq,
  input logic       stat_int
);
  logic wr_hit, rd_hit;
  assign wr_hit = bus_cs & bus_wr & hit;
  assign rd_hit = bus_cs & ~bus_wr & hit;

  p_lo_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd1) |=> (pblk_addr == {8'h00, $past(bus_wdata)}));

  p_start_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd2) |=> start_pulse);

  p_start_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(wr_hit && off == 3'd2));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && off == 3'd1 && !done_valid) |=> (!irq && !stat_int));

  p_done_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(wr_hit && off == 3'd7)) |=> irq);

  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && off == 3'd3) |=> stop_pulse);

  p_quiet_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (bus_rdata == 8'h00));
endmodule

bind dskc_hostregs dskc_hostregs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit), .off(off),
  .done_valid(done_valid), .pblk_addr(pblk_addr), .start_pulse(start_pulse),
  .stop_pulse(stop_pulse), .irq(irq), .stat_int(stat_int)
);

// File: tb/sim_dskc_hostregs.sv
module sim_dskc_hostregs;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MASK = 4'b1011;
  localparam int BASE = 8'h78;
  localparam int GAP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_cs = 0, bus_wr = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic done_valid = 0, done_rdychg = 0;
  logic [7:0] done_rtype = 0, done_rbyte0 = 0;
  logic [15:0] pblk_addr;
  logic start_pulse, stop_pulse, sysrst_pulse, irq;

  int n_tests = 0, n_fail = 0, cycles = 0;

  // model state
  logic m_intff, m_int, m_rdychg;
  logic [7:0] m_rtype, m_rbyte0;
  logic [15:0] m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dskc_hostregs #(.ADDR_W(8), .BASE(BASE), .ALIAS_GAP(GAP), .DRIVE_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_valid(done_valid),
    .done_rtype(done_rtype), .done_rbyte0(done_rbyte0), .done_rdychg(done_rdychg),
    .pblk_addr(pblk_addr), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .sysrst_pulse(sysrst_pulse), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int off_of(input logic [7:0] a);
    if (a >= BASE && a < BASE + 8) return a - BASE;
    if (a >= BASE + GAP && a < BASE + GAP + 8) return a - BASE - GAP;
    return -1;
  endfunction

  function automatic logic [7:0] rdy_byte();
    return {MASK[1], MASK[0], MASK[3], MASK[2], 4'b0000};
  endfunction

  function automatic logic [7:0] exp_read(input int o);
    case (o)
      0: return {MASK, 1'b0, m_int, 1'b0, 1'b1};
      1: return m_rtype;
      3: return (m_rtype == 8'h00) ? m_rbyte0 : (m_rdychg ? rdy_byte() : 8'h00);
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_intff = 0; m_int = 0; m_rdychg = 0; m_rtype = 0; m_rbyte0 = 0; m_addr = 0;
  endtask

  // one bus cycle; checks read data before the edge and pulses after it
  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [7:0] d, input string req);
    int o;
    logic e_start, e_stop, e_sys;
    o = off_of(a);
    @(negedge clk);
    bus_cs = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (!wr) chk(req, {8'h00, bus_rdata}, {8'h00, (o < 0) ? 8'h00 : exp_read(o)});
    e_start = 0; e_stop = 0; e_sys = 0;
    if (o >= 0) begin
      if (!wr && o == 1) begin m_intff = 0; m_int = 0; end
      if (wr && o == 1) m_addr = {8'h00, d};
      if (wr && o == 2) begin m_addr[15:8] = m_addr[15:8] | d; e_start = 1; if (m_intff) m_int = 1; end
      if (wr && o == 3) e_stop = 1;
      if (wr && o == 7) begin e_sys = 1; m_intff = 0; m_int = 0; m_rtype = 0; m_rbyte0 = 0; m_rdychg = 0; end
    end
    @(posedge clk); #1;
    bus_cs = 0; bus_wr = 0;
    chk({req, " addr"}, pblk_addr, m_addr);
    chk({req, " pulses"}, {13'd0, start_pulse, stop_pulse, sysrst_pulse}, {13'd0, e_start, e_stop, e_sys});
    chk({req, " irq"}, {15'd0, irq}, {15'd0, m_intff});
  endtask

  task automatic complete(input logic [7:0] rt, input logic [7:0] rb, input logic rc);
    @(negedge clk);
    done_valid = 1; done_rtype = rt; done_rbyte0 = rb; done_rdychg = rc;
    @(posedge clk); #1;
    done_valid = 0;
    m_intff = 1; m_rtype = rt; m_rbyte0 = rb; if (rc) m_rdychg = 1;
    chk("R6 irq set", {15'd0, irq}, 16'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9 addr", pblk_addr, 16'h0000);
    chk("R9 pulses", {12'd0, start_pulse, stop_pulse, sysrst_pulse, irq}, 16'd0);
    rst_n = 1;
    bus_op(0, 8'h78, 0, "R9 R2 status after reset");
    bus_op(0, 8'h79, 0, "R9 rtype OK");
    bus_op(0, 8'h7B, 0, "R9 R7 result byte 0");
    // R1: alias window and neighbours
    bus_op(0, 8'h88, 0, "R1 alias status");
    bus_op(0, 8'h77, 0, "R1 below window");
    bus_op(0, 8'h80, 0, "R1 between windows");
    bus_op(0, 8'h90, 0, "R1 above alias");
    bus_op(1, 8'h81, 8'h55, "R1 write outside ignored");
    // R4/R5 address assembly
    bus_op(1, 8'h79, 8'h34, "R4 low write");
    bus_op(1, 8'h8A, 8'h12, "R5 high write alias");
    bus_op(1, 8'h7A, 8'h40, "R5 high OR");
    bus_op(1, 8'h89, 8'hAB, "R4 low replaces high");
    // R5 int bit armed by completion
    complete(8'h00, 8'hE0, 1'b0);
    bus_op(0, 8'h7B, 0, "R7 rbyte0 with type OK");
    bus_op(1, 8'h7A, 8'h01, "R5 arm int");
    bus_op(0, 8'h78, 0, "R2 R5 status int set");
    bus_op(0, 8'h79, 0, "R3 ack");
    bus_op(0, 8'h88, 0, "R3 status int cleared");
    // R8 result byte variants
    complete(8'h02, 8'h20, 1'b0);
    bus_op(0, 8'h8B, 0, "R8 no ready change -> 0");
    complete(8'h02, 8'h20, 1'b1);
    bus_op(0, 8'h7B, 0, "R8 drive-ready byte");
    // R11 undecoded offsets
    bus_op(0, 8'h7C, 0, "R11 read offset 4");
    bus_op(0, 8'h7F, 0, "R11 read offset 7");
    bus_op(1, 8'h78, 8'hFF, "R11 write offset 0");
    bus_op(1, 8'h8D, 8'hFF, "R11 write offset 5");
    bus_op(0, 8'h78, 0, "R11 status unchanged");
    // R10 stop and system reset
    bus_op(1, 8'h7B, 8'h00, "R10 stop");
    bus_op(1, 8'h8F, 8'h00, "R10 system reset");
    bus_op(0, 8'h79, 0, "R10 rtype back to OK");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [7:0] a;
      k = $urandom_range(0, 9);
      a = (k < 4) ? 8'(BASE + $urandom_range(0, 7)) :
          (k < 8) ? 8'(BASE + GAP + $urandom_range(0, 7)) :
                    8'(BASE - 2 + $urandom_range(0, 28));
      if ($urandom_range(0, 5) == 0)
        complete(($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom_range(1, 3)),
                 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
      else if ($urandom_range(0, 2) == 0 && off_of(a) == 7)
        bus_op(0, a, 0, "R11 random read");
      else
        bus_op(1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)), "R1 random access");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule